// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port attached to a simple word-addressed register bus. Software drives the pins through a stored output value and a per-pin direction. The output value can be written whole, or changed through atomic set, clear and toggle write addresses that touch only the bits marked in the written mask.

Each input pin is brought into the clock domain through a synchronizer. It is then compared against a per-pin trigger condition. The condition can be a low level, a high level, a rising edge or a falling edge. A per-pin override instead fires on any change. Each match latches a per-pin flag, and software clears a flag by writing a one to it. A per-pin enable mask combines the latched flags into a single interrupt request line.

The read port is combinational and qualified by the read strobe. The write strobe acts on the next rising clock edge.

Top module: `gpio_port_irq`

## Requirements
- R1: Offset 0 holds the stored output value. A write stores the word, `pin_out` equals the stored value, and a read of offset 0 returns the stored value whatever `pin_in` carries.
- R2: Offset 1 holds the direction word (1 = drive, 0 = input). `pin_oe` equals it from the cycle after the write.
- R3: Writes to offsets 2, 3 and 4 respectively OR, AND-NOT and XOR the written mask into the stored output value. Bits where the mask is 0 are untouched. These offsets read as zero.
- R4: Each pin has a 2-bit trigger code: 0 low level, 1 high level, 2 rising edge, 3 falling edge. Pin n below 16 uses bits [2n+1:2n] of offset 5. Pin n from 16 up uses bits [2(n-16)+1:2(n-16)] of offset 6.
- R5: When a pin's bit in the any-edge word at offset 7 is 1, its trigger code is ignored and both rising and falling changes set its flag.
- R6: Writing 1 to a bit of the flag word at offset 9 clears that flag. Writing 0 leaves it unchanged. Without a write, a set flag stays set.
- R7: A level match sets the flag on every cycle the level holds. A set and a write-one-clear in the same cycle leave the flag set.
- R8: `irq` is high when any flag is set whose bit in the enable mask at offset 8 is 1. A pin with mask 0 still latches its flag.
- R9: Reset clears every register. All pins are therefore inputs, `pin_out`, `pin_oe` and `irq` are 0, and every code is low level, so held-low inputs set all flags right after reset.
- R10: A change on `pin_in` made between clock edges first shows in the flag word after the third following rising edge: two synchronizer stages, then the flag register.
- R11: Unused offsets 10 to 15 read as zero. `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_rd | input | 1 | Read strobe, qualifies `bus_rdata` |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Per-pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Every cycle, the assertions check the following:
- the next value of `pin_out` after a direct, set, clear or toggle write, and that it holds when no such write occurs;
- that `pin_oe` follows a direction write;
- that any detected event lands in the flag word, and that flags are sticky apart from write-one clears;
- that a zero mask keeps `irq` low.

Only the bench's scenarios can show that the detection matches each trigger code for each pin and for the any-edge override. Its sweep covers several code rotations, override masks and input pairs. The scenarios also show the placement of codes across the two configuration words, the exact three-edge input latency, and the state after reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 4'd0,
    REG_DIR     = 4'd1,
    REG_SET     = 4'd2,
    REG_CLR     = 4'd3,
    REG_TOG     = 4'd4,
    REG_TRIG_LO = 4'd5,
    REG_TRIG_HI = 4'd6,
    REG_ANYEDGE = 4'd7,
    REG_MASK    = 4'd8,
    REG_FLAG    = 4'd9
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_code_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync,
  output logic [WIDTH-1:0] sync_prev
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;
  logic [WIDTH-1:0]             prev_q;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync      = chain_q[STAGES-1];
  assign sync_prev = prev_q;

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] sync,
  input  logic [NUM_PINS-1:0] sync_prev,
  input  logic [NUM_PINS-1:0] trig_lo,
  input  logic [NUM_PINS-1:0] trig_hi,
  input  logic [NUM_PINS-1:0] any_edge,
  output logic [NUM_PINS-1:0] evt
);

  localparam int HALF = NUM_PINS / 2;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [1:0] code;
    logic       rise;
    logic       fall;

    if (g < HALF) begin : g_lo
      assign code = trig_lo[2*g +: 2];
    end else begin : g_hi
      assign code = trig_hi[2*(g-HALF) +: 2];
    end

    assign rise = sync[g] & ~sync_prev[g];
    assign fall = ~sync[g] & sync_prev[g];

    always_comb begin
      if (any_edge[g]) begin
        evt[g] = rise | fall;
      end else begin
        case (trig_code_e'(code))
          TRIG_LOW:  evt[g] = ~sync[g];
          TRIG_HIGH: evt[g] = sync[g];
          TRIG_RISE: evt[g] = rise;
          default:   evt[g] = fall;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_flag_reg.sv
module gpio_flag_reg #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_evt,
  input  logic                clr_en,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] flags
);

  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] flag_d;
  logic [NUM_PINS-1:0] clr_eff;
  logic                flag_en;

  always_comb begin
    clr_eff = clr_en ? clr_mask : '0;
    flag_d  = (flag_q & ~clr_eff) | set_evt;
    flag_en = clr_en | (|set_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  logic rst_sync_n;

  logic [NUM_PINS-1:0] data_q, data_d;
  logic [NUM_PINS-1:0] dir_q, dir_d;
  logic [NUM_PINS-1:0] trig_lo_q, trig_lo_d;
  logic [NUM_PINS-1:0] trig_hi_q, trig_hi_d;
  logic [NUM_PINS-1:0] any_q, any_d;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic data_en, dir_en, trig_lo_en, trig_hi_en, any_en, mask_en;

  logic [NUM_PINS-1:0] in_sync, in_prev, evt, status_q;
  logic                flag_clr_en;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .din       (pin_in),
    .sync      (in_sync),
    .sync_prev (in_prev)
  );

  gpio_event_detect #(
    .NUM_PINS (NUM_PINS)
  ) u_detect (
    .sync      (in_sync),
    .sync_prev (in_prev),
    .trig_lo   (trig_lo_q),
    .trig_hi   (trig_hi_q),
    .any_edge  (any_q),
    .evt       (evt)
  );

  assign flag_clr_en = bus_wr && (bus_addr == REG_FLAG);

  gpio_flag_reg #(
    .NUM_PINS (NUM_PINS)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_evt  (evt),
    .clr_en   (flag_clr_en),
    .clr_mask (bus_wdata),
    .flags    (status_q)
  );

  // output value: direct write plus the three atomic aliases
  always_comb begin
    data_d  = data_q;
    data_en = 1'b0;
    if (bus_wr) begin
      case (bus_addr)
        REG_DATA: begin data_d = bus_wdata;           data_en = 1'b1; end
        REG_SET:  begin data_d = data_q | bus_wdata;  data_en = 1'b1; end
        REG_CLR:  begin data_d = data_q & ~bus_wdata; data_en = 1'b1; end
        REG_TOG:  begin data_d = data_q ^ bus_wdata;  data_en = 1'b1; end
        default:  ;
      endcase
    end
  end

  // plain configuration words
  always_comb begin
    dir_d      = bus_wdata;
    trig_lo_d  = bus_wdata;
    trig_hi_d  = bus_wdata;
    any_d      = bus_wdata;
    mask_d     = bus_wdata;
    dir_en     = bus_wr && (bus_addr == REG_DIR);
    trig_lo_en = bus_wr && (bus_addr == REG_TRIG_LO);
    trig_hi_en = bus_wr && (bus_addr == REG_TRIG_HI);
    any_en     = bus_wr && (bus_addr == REG_ANYEDGE);
    mask_en    = bus_wr && (bus_addr == REG_MASK);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q    <= '0;
      dir_q     <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      any_q     <= '0;
      mask_q    <= '0;
    end else begin
      if (data_en)    data_q    <= data_d;
      if (dir_en)     dir_q     <= dir_d;
      if (trig_lo_en) trig_lo_q <= trig_lo_d;
      if (trig_hi_en) trig_hi_q <= trig_hi_d;
      if (any_en)     any_q     <= any_d;
      if (mask_en)    mask_q    <= mask_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        REG_DATA:    bus_rdata = data_q;
        REG_DIR:     bus_rdata = dir_q;
        REG_TRIG_LO: bus_rdata = trig_lo_q;
        REG_TRIG_HI: bus_rdata = trig_hi_q;
        REG_ANYEDGE: bus_rdata = any_q;
        REG_MASK:    bus_rdata = mask_q;
        REG_FLAG:    bus_rdata = status_q;
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign irq     = |(status_q & mask_q);

endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] status,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] mask
);

  logic wr_data, wr_set, wr_clr, wr_tog, wr_dir, wr_flag;
  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_set  = bus_wr && (bus_addr == REG_SET);
  assign wr_clr  = bus_wr && (bus_addr == REG_CLR);
  assign wr_tog  = bus_wr && (bus_addr == REG_TOG);
  assign wr_dir  = bus_wr && (bus_addr == REG_DIR);
  assign wr_flag = bus_wr && (bus_addr == REG_FLAG);

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> pin_out == $past(bus_wdata)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || wr_set || wr_clr || wr_tog) |=> $stable(pin_out)); // R1
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata)); // R2
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> pin_out == ($past(pin_out) | $past(bus_wdata))); // R3
  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R3
  AST_TOG_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tog |=> pin_out == ($past(pin_out) ^ $past(bus_wdata))); // R3
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> (status & $past(bus_wdata) & ~$past(evt)) == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> (status & $past(status)) == $past(status)); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (status & $past(evt)) == $past(evt)); // R7
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8

endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .status    (status_q),
  .evt       (evt),
  .mask      (mask_q)
);

// File: tb/gpio_port_irq_bench.sv
`timescale 1ns/1ps
module gpio_port_irq_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int total;
  int bad;
  bit done;

  localparam logic [3:0] A_DATA = 4'd0, A_DIR = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                         A_TOG = 4'd4, A_TLO = 4'd5, A_THI = 4'd6, A_ANY = 4'd7,
                         A_MASK = 4'd8, A_FLAG = 4'd9;

  gpio_port_irq u_gpio_port_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [1:0] code_of(int n, int rot);
    return 2'((n + rot + ((n >= 16) ? 1 : 0)) % 4);
  endfunction

  function automatic logic [31:0] cfg_word(int rot, bit hi);
    logic [31:0] w;
    for (int j = 0; j < 16; j++) w[2*j +: 2] = code_of(hi ? j + 16 : j, rot);
    return w;
  endfunction

  function automatic logic [31:0] exp_flags(logic [31:0] a, logic [31:0] b, int rot, logic [31:0] es);
    logic [31:0] f;
    for (int n = 0; n < 32; n++) begin
      if (es[n]) f[n] = a[n] ^ b[n];
      else case (code_of(n, rot))
        2'd0: f[n] = ~(a[n] & b[n]);
        2'd1: f[n] = a[n] | b[n];
        2'd2: f[n] = ~a[n] & b[n];
        default: f[n] = a[n] & ~b[n];
      endcase
    end
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] a, b, es, m, expf;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R9 reset state
    chk("R9 pin_out", pin_out, 32'h0);
    chk("R9 pin_oe", pin_oe, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    for (int r = 0; r < 9; r++) begin
      rd_reg(4'(r), rd);
      chk($sformatf("R9 reg %0d", r), rd, 32'h0);
    end
    rd_reg(A_FLAG, rd);
    chk("R9 low-level default flags", rd, 32'hFFFF_FFFF);
    // R11 unused offsets and idle read
    for (int r = 10; r < 16; r++) begin
      rd_reg(4'(r), rd);
      chk($sformatf("R11 offset %0d", r), rd, 32'h0);
    end
    @(negedge clk); bus_addr = A_FLAG; #2;
    chk("R11 idle read", bus_rdata, 32'h0);

    // R1 R2 R3 data path
    wr_reg(A_DIR, 32'hFFFF_0000);
    chk("R2 oe", pin_oe, 32'hFFFF_0000);
    pin_in = 32'hDEAD_BEEF;
    wr_reg(A_DATA, 32'h1234_5678);
    chk("R1 pin_out", pin_out, 32'h1234_5678);
    rd_reg(A_DATA, rd);
    chk("R1 readback ignores pins", rd, 32'h1234_5678);
    wr_reg(A_SET, 32'h0000_F00F);
    chk("R3 set", pin_out, 32'h1234_F67F);
    wr_reg(A_CLR, 32'h0030_0070);
    chk("R3 clear", pin_out, 32'h1204_F60F);
    wr_reg(A_TOG, 32'hFF00_00FF);
    chk("R3 toggle", pin_out, 32'hED04_F6F0);
    rd_reg(A_SET, rd); chk("R3 set alias reads 0", rd, 32'h0);
    rd_reg(A_CLR, rd); chk("R3 clear alias reads 0", rd, 32'h0);
    rd_reg(A_TOG, rd); chk("R3 toggle alias reads 0", rd, 32'h0);
    wr_reg(A_DIR, 32'h0000_00A5);
    chk("R2 oe rewrite", pin_oe, 32'h0000_00A5);

    // R4 R5 R7 R8 sweep over codes, overrides and input pairs
    for (int rot = 0; rot < 4; rot++) begin
      for (int e = 0; e < 3; e++) begin
        es = (e == 0) ? 32'h0 : (e == 1) ? 32'h0F0F_00FF : 32'hFFFF_FFFF;
        wr_reg(A_TLO, cfg_word(rot, 1'b0));
        wr_reg(A_THI, cfg_word(rot, 1'b1));
        wr_reg(A_ANY, es);
        rd_reg(A_TLO, rd); chk("R4 low word readback", rd, cfg_word(rot, 1'b0));
        for (int k = 0; k < 8; k++) begin
          a = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : $urandom();
          b = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h0 : $urandom();
          @(negedge clk); pin_in = a;
          settle();
          wr_reg(A_FLAG, 32'hFFFF_FFFF);
          pin_in = b;
          settle();
          expf = exp_flags(a, b, rot, es);
          rd_reg(A_FLAG, rd);
          chk($sformatf("R4 R5 flags rot=%0d es=%h", rot, es), rd, expf);
          m = $urandom();
          wr_reg(A_MASK, m);
          chk("R8 irq from masked flags", {31'b0, irq}, {31'b0, |(expf & m)});
        end
      end
    end

    // R7 set wins over clear for a held level
    wr_reg(A_MASK, 32'h0);
    wr_reg(A_ANY, 32'h0);
    wr_reg(A_TLO, 32'h5555_5555);
    wr_reg(A_THI, 32'h5555_5555);
    @(negedge clk); pin_in = 32'h0000_0001;
    settle();
    wr_reg(A_FLAG, 32'hFFFF_FFFF);
    rd_reg(A_FLAG, rd);
    chk("R7 held level survives clear", rd, 32'h0000_0001);
    @(negedge clk); pin_in = 32'h0;
    settle();
    wr_reg(A_FLAG, 32'hFFFF_FFFF);
    rd_reg(A_FLAG, rd);
    chk("R7 clear after level gone", rd, 32'h0);

    // R6 write-one-clear, R8 masked pin latches
    wr_reg(A_TLO, 32'hAAAA_AAAA);
    wr_reg(A_THI, 32'hAAAA_AAAA);
    settle();
    wr_reg(A_FLAG, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0000_0008;
    settle();
    @(negedge clk); pin_in = 32'h0;
    settle();
    rd_reg(A_FLAG, rd);
    chk("R8 masked pin still latches", rd, 32'h0000_0008);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);
    wr_reg(A_FLAG, 32'h0);
    rd_reg(A_FLAG, rd);
    chk("R6 write zero keeps", rd, 32'h0000_0008);
    wr_reg(A_FLAG, 32'h0000_0001);
    rd_reg(A_FLAG, rd);
    chk("R6 other bit keeps", rd, 32'h0000_0008);
    wr_reg(A_MASK, 32'h0000_0008);
    chk("R8 unmasked irq high", {31'b0, irq}, 32'h1);
    wr_reg(A_FLAG, 32'h0000_0008);
    rd_reg(A_FLAG, rd);
    chk("R6 write one clears", rd, 32'h0);
    chk("R8 irq drops", {31'b0, irq}, 32'h0);

    // R10 latency: rising code, change between edges
    @(negedge clk); pin_in = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk); rd_now(A_FLAG, rd);
    chk("R10 not yet after two edges", rd, 32'h0);
    @(negedge clk); rd_now(A_FLAG, rd);
    chk("R10 set after third edge", rd, 32'h0000_0020);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule